// File: doc/BRIEF.md
# Sector Bit Corrector

The block repairs one 512-byte data sector held in an external synchronous buffer RAM. An error locator reports up to eight bit positions per sector. The positions are numbered from the end of the codeword, so the check bits come first and the data bits follow. Given a strength setting, the block works out how many check bits there are. It drops every position that points at a check bit or past the end of the sector. Each remaining position is turned into a byte address and a bit within that byte, and that bit is inverted with a read-modify-write on the RAM.

A sector is started with a one-cycle `start_i` pulse. The pulse latches the location list, the count and the strength. The stored check bytes are also examined at that pulse: if every stored check byte reads 0xFF, the sector is treated as freshly erased and no correction is made. The block signals completion with a one-cycle `done_o` pulse and reports how many data bits it inverted.

Top module: `sector_bit_corrector`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ram_re_o`, `ram_we_o` and `fixed_cnt_o` are all zero.
- R2: Strength code 0 means 52 check bits, code 1 means 104, and codes 2 and 3 mean 208. For a location L with L ≥ C and L − C < 4096 (C is the check-bit count), let A = L − C. The bit at position A mod 8 of byte (4095 − A) / 8 is inverted.
- R3: A location below C, or at or beyond C + 4096, causes no RAM access, leaves the sector unchanged and is not counted. It costs one cycle.
- R4: Each data location is one read cycle (`ram_re_o`) followed by one write cycle (`ram_we_o`) to the same address. The write data is the read data XOR a one-hot mask. Read and write are never high together.
- R5: Locations are applied in list order, with slot k at bits [13k+12:13k] of `err_loc_i`. Repeated hits on the same byte accumulate, and a bit hit twice returns to its original value.
- R6: A count of zero raises `done_o` in the cycle after the start edge, with no RAM access and `fixed_cnt_o` = 0.
- R7: Stored check byte k sits at bits [8k+7:8k] of `code_i`. Bytes 0..6 are checked for code 0, bytes 0..13 for code 1, and bytes 0..25 for codes 2 and 3. If all checked bytes equal 0xFF, the block skips correction and behaves as in R6. A single checked byte that differs re-enables correction.
- R8: Counts above 8 are treated as 8.
- R9: Let D be the number of data locations and S the number of skipped locations. `done_o` is a one-cycle pulse visible after the (2D+S)-th clock edge following the start edge, and `fixed_cnt_o` then equals D.
- R10: A `start_i` pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one sector (accepted when idle) |
| strength_i | input | 2 | Code strength: 0, 1, 2/3 |
| err_cnt_i | input | 4 | Number of valid locations |
| err_loc_i | input | 104 | Eight 13-bit locations, slot 0 lowest |
| code_i | input | 208 | Stored check bytes, byte 0 lowest |
| ram_addr_o | output | 9 | Buffer RAM byte address |
| ram_re_o | output | 1 | RAM read strobe, data returned next cycle |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |
| busy_o | output | 1 | Sector in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fixed_cnt_o | output | 4 | Data bits inverted for the last sector |

## Verification
Take the edge that samples `start_i` as edge zero. The completion pulse is due after edge 2D+S, where each data location takes two edges and each skipped location one. For zero counts and erased sectors it is due right after edge zero. The bench counts edges from the start edge and samples `done_o` at each falling edge. It compares that count with the value it derives from the location list. One cycle later it confirms that the pulse has dropped. Sector contents, the write total and `fixed_cnt_o` are then compared with a model the bench builds from the mapping rule.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} fix_state_e;

  // check bits that precede the data in location numbering
  function automatic int unsigned check_bits(logic [1:0] s);
    case (s)
      2'd0:    return 52;
      2'd1:    return 104;
      default: return 208;
    endcase
  endfunction

  // stored check bytes examined for the erased test
  function automatic int unsigned check_bytes(logic [1:0] s);
    case (s)
      2'd0:    return 7;
      2'd1:    return 14;
      default: return 26;
    endcase
  endfunction
endpackage

// File: rtl/loc_map.sv
module loc_map import corr_pkg::*; #(
  parameter int LOC_W      = 13,
  parameter int DATA_BYTES = 512
) (
  input  logic [LOC_W-1:0]              loc_i,
  input  logic [1:0]                    strength_i,
  output logic                          valid_o,
  output logic [$clog2(DATA_BYTES)-1:0] byte_o,
  output logic [7:0]                    mask_o
);
  localparam int DATA_BITS = DATA_BYTES * 8;
  localparam int BIT_W     = $clog2(DATA_BITS);
  localparam logic [LOC_W:0]   DBITS_EXT = (LOC_W+1)'(DATA_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_BITS - 1);

  logic [LOC_W-1:0] cb;
  logic [LOC_W-1:0] adj;
  logic [BIT_W-1:0] rev;

  always_comb begin
    cb      = LOC_W'(check_bits(strength_i));
    adj     = loc_i - cb;
    valid_o = (loc_i >= cb) && ({1'b0, adj} < DBITS_EXT);
    rev     = LAST_BIT - adj[BIT_W-1:0];  // mirror: bit 0 of data is last
    byte_o  = rev[BIT_W-1:3];
    mask_o  = 8'd1 << adj[2:0];
  end
endmodule

// File: rtl/erase_detect.sv
module erase_detect import corr_pkg::*; #(
  parameter int CODE_BYTES_MAX = 26
) (
  input  logic [CODE_BYTES_MAX*8-1:0] code_i,
  input  logic [1:0]                  strength_i,
  output logic                        erased_o
);
  logic [CODE_BYTES_MAX-1:0] byte_ok;

  for (genvar k = 0; k < CODE_BYTES_MAX; k++) begin : g_byte
    assign byte_ok[k] = (code_i[8*k +: 8] == 8'hFF) ||
                        (k >= int'(check_bytes(strength_i)));
  end

  assign erased_o = &byte_ok;
endmodule

// File: rtl/fix_ctrl.sv
module fix_ctrl import corr_pkg::*; #(
  parameter int MAX_ERR    = 8,
  parameter int LOC_W      = 13,
  parameter int DATA_BYTES = 512
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [1:0]                      strength_i,
  input  logic [$clog2(MAX_ERR+1)-1:0]    cnt_i,
  input  logic [MAX_ERR*LOC_W-1:0]        locs_i,
  input  logic                            bypass_i,
  output logic [LOC_W-1:0]                cur_loc_o,
  output logic [1:0]                      strength_o,
  input  logic                            map_valid_i,
  input  logic [$clog2(DATA_BYTES)-1:0]   map_byte_i,
  input  logic [7:0]                      map_mask_i,
  output logic [$clog2(DATA_BYTES)-1:0]   ram_addr_o,
  output logic                            ram_re_o,
  output logic                            ram_we_o,
  output logic [7:0]                      ram_wdata_o,
  input  logic [7:0]                      ram_rdata_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic [$clog2(MAX_ERR+1)-1:0]    fixed_cnt_o
);
  localparam int CNT_W  = $clog2(MAX_ERR+1);
  localparam int IDX_W  = $clog2(MAX_ERR);
  localparam int ADDR_W = $clog2(DATA_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ERR);

  fix_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q, fixed_q, eff_cnt;
  logic [1:0]        str_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        mask_q;
  logic              done_q, last_loc;
  logic [LOC_W-1:0]  locs_q [MAX_ERR];

  assign eff_cnt  = (cnt_i > CNT_MAX) ? CNT_MAX : cnt_i;
  assign last_loc = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

  assign cur_loc_o   = locs_q[idx_q];
  assign strength_o  = str_q;
  assign ram_re_o    = (state_q == ST_READ) && map_valid_i;
  assign ram_we_o    = (state_q == ST_WRITE);
  assign ram_addr_o  = (state_q == ST_WRITE) ? addr_q : map_byte_i;
  assign ram_wdata_o = ram_rdata_i ^ mask_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign fixed_cnt_o = fixed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      fixed_q <= '0;
      str_q   <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
      for (int i = 0; i < MAX_ERR; i++) locs_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          fixed_q <= '0;
          if (eff_cnt == '0 || bypass_i) begin
            done_q <= 1'b1;
          end else begin
            cnt_q   <= eff_cnt;
            str_q   <= strength_i;
            idx_q   <= '0;
            for (int i = 0; i < MAX_ERR; i++) locs_q[i] <= locs_i[i*LOC_W +: LOC_W];
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (map_valid_i) begin
            addr_q  <= map_byte_i;
            mask_q  <= map_mask_i;
            state_q <= ST_WRITE;
          end else if (last_loc) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_WRITE: begin
          fixed_q <= fixed_q + 1'b1;
          if (last_loc) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_rmw_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ($past(ram_re_o) && ram_addr_o == $past(ram_addr_o)));
  assert_no_rw_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_re_o && ram_we_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_fixed_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fixed_cnt_o <= CNT_MAX);
  assert_zero_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && cnt_i == '0) |=> (done_o && !busy_o && !ram_re_o));
  assert_erased_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bypass_i) |=> (done_o && !busy_o && fixed_cnt_o == '0));
  assert_read_only_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |-> map_valid_i);
endmodule

// File: rtl/sector_bit_corrector.sv
module sector_bit_corrector import corr_pkg::*; #(
  parameter int MAX_ERR        = 8,
  parameter int LOC_W          = 13,
  parameter int DATA_BYTES     = 512,
  parameter int CODE_BYTES_MAX = 26
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [1:0]                    strength_i,
  input  logic [$clog2(MAX_ERR+1)-1:0]  err_cnt_i,
  input  logic [MAX_ERR*LOC_W-1:0]      err_loc_i,
  input  logic [CODE_BYTES_MAX*8-1:0]   code_i,
  output logic [$clog2(DATA_BYTES)-1:0] ram_addr_o,
  output logic                          ram_re_o,
  output logic                          ram_we_o,
  output logic [7:0]                    ram_wdata_o,
  input  logic [7:0]                    ram_rdata_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [$clog2(MAX_ERR+1)-1:0]  fixed_cnt_o
);
  localparam int ADDR_W = $clog2(DATA_BYTES);

  logic              erased;
  logic [LOC_W-1:0]  cur_loc;
  logic [1:0]        cur_str;
  logic              map_valid;
  logic [ADDR_W-1:0] map_byte;
  logic [7:0]        map_mask;

  erase_detect #(.CODE_BYTES_MAX(CODE_BYTES_MAX)) u_erase (
    .code_i     (code_i),
    .strength_i (strength_i),
    .erased_o   (erased)
  );

  loc_map #(.LOC_W(LOC_W), .DATA_BYTES(DATA_BYTES)) u_map (
    .loc_i      (cur_loc),
    .strength_i (cur_str),
    .valid_o    (map_valid),
    .byte_o     (map_byte),
    .mask_o     (map_mask)
  );

  fix_ctrl #(.MAX_ERR(MAX_ERR), .LOC_W(LOC_W), .DATA_BYTES(DATA_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .strength_i  (strength_i),
    .cnt_i       (err_cnt_i),
    .locs_i      (err_loc_i),
    .bypass_i    (erased),
    .cur_loc_o   (cur_loc),
    .strength_o  (cur_str),
    .map_valid_i (map_valid),
    .map_byte_i  (map_byte),
    .map_mask_i  (map_mask),
    .ram_addr_o  (ram_addr_o),
    .ram_re_o    (ram_re_o),
    .ram_we_o    (ram_we_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_rdata_i (ram_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fixed_cnt_o (fixed_cnt_o)
  );
endmodule

// File: tb/sector_bit_corrector_test.sv
`timescale 1ns/1ps
module sector_bit_corrector_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   strength = '0;
  logic [3:0]   err_cnt = '0;
  logic [103:0] err_loc = '0;
  logic [207:0] code = '0;
  logic [8:0]   ram_addr;
  logic         ram_re, ram_we;
  logic [7:0]   ram_wdata;
  logic [7:0]   ram_rdata = '0;
  logic         busy, done;
  logic [3:0]   fixed_cnt;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] mem     [512];
  logic [7:0] ref_mem [512];

  always #2.5 clk = ~clk;

  sector_bit_corrector uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .strength_i(strength),
    .err_cnt_i(err_cnt), .err_loc_i(err_loc), .code_i(code),
    .ram_addr_o(ram_addr), .ram_re_o(ram_re), .ram_we_o(ram_we),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .busy_o(busy), .done_o(done), .fixed_cnt_o(fixed_cnt)
  );

  always @(posedge clk) begin
    if (ram_we) begin mem[ram_addr] <= ram_wdata; wr_cnt <= wr_cnt + 1; end
    if (ram_re) begin ram_rdata <= mem[ram_addr]; rd_cnt <= rd_cnt + 1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [103:0] pack(input int l0, l1, l2, l3, l4, l5, l6, l7);
    logic [103:0] v;
    v[12:0]   = 13'(l0); v[25:13]  = 13'(l1); v[38:26]  = 13'(l2); v[51:39]  = 13'(l3);
    v[64:52]  = 13'(l4); v[77:65]  = 13'(l5); v[90:78]  = 13'(l6); v[103:91] = 13'(l7);
    return v;
  endfunction

  // Runs one sector; inject=1 pulses a conflicting start while busy (R10)
  task automatic run_case(input logic [1:0] s, input int c, input logic [103:0] lv,
                          input logic [207:0] cd, input bit inject, input string req);
    int cb, nb, n_eff, dcount, scount, t_exp, n, mism;
    bit erased, seen;
    cb = (s == 0) ? 52 : (s == 1) ? 104 : 208;
    nb = (s == 0) ? 7 : (s == 1) ? 14 : 26;
    erased = 1;
    for (int k = 0; k < nb; k++) if (cd[8*k +: 8] != 8'hFF) erased = 0;
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'((i * 37 + 5) & 255);
      ref_mem[i] = mem[i];
    end
    n_eff = (c > 8) ? 8 : c;
    dcount = 0; scount = 0;
    if (!erased) begin
      for (int i = 0; i < n_eff; i++) begin
        int l, a;
        l = int'(lv[13*i +: 13]);
        if (l >= cb && l - cb < 4096) begin
          a = l - cb;
          ref_mem[(4095 - a) / 8] ^= 8'(1 << (a % 8));
          dcount++;
        end else scount++;
      end
    end
    t_exp = 2 * dcount + scount;
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0;
    strength = s; err_cnt = 4'(c); err_loc = lv; code = cd; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0; seen = done;
    while (!seen && n < 64) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (inject && n == 1) begin
        start = 1'b1; strength = 2'd0; err_cnt = 4'd8; err_loc = pack(52,53,54,55,56,57,58,59);
        code = '0;
      end else start = 1'b0;
      seen = done;
    end
    start = 1'b0;
    check(seen && n == t_exp, {req, " R9 done edge"}, n, t_exp);
    check(fixed_cnt == 4'(dcount), {req, " R9 fixed count"}, fixed_cnt, dcount);
    check(wr_cnt == dcount && rd_cnt == dcount, {req, " R4 ram accesses"}, wr_cnt + rd_cnt, 2 * dcount);
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) mism++;
    check(mism == 0, {req, " R2 sector bytes"}, mism, 0);
    @(posedge clk);
    @(negedge clk);
    check(!done && !busy, {req, " R9 pulse width"}, done, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !ram_re && !ram_we && fixed_cnt == 0, "R1 reset state",
          int'({busy, done, ram_re, ram_we, fixed_cnt}), 0);
  endtask
  task automatic t_map8();   run_case(2'd1, 1, pack(104,0,0,0,0,0,0,0), '0, 0, "R2 strength8 first bit"); endtask
  task automatic t_map4();   run_case(2'd0, 3, pack(52,60,4147,0,0,0,0,0), '0, 0, "R2 strength4"); endtask
  task automatic t_map16();  run_case(2'd2, 2, pack(221,4303,0,0,0,0,0,0), '0, 0, "R2 strength16"); endtask
  task automatic t_map16b(); run_case(2'd3, 1, pack(300,0,0,0,0,0,0,0), '0, 0, "R2 strength code3"); endtask
  task automatic t_skip();   run_case(2'd1, 4, pack(0,103,4200,150,0,0,0,0), '0, 0, "R3 skip check bits"); endtask
  task automatic t_order();  run_case(2'd1, 3, pack(104,105,104,0,0,0,0,0), '0, 0, "R5 same byte order"); endtask
  task automatic t_rmw();    run_case(2'd1, 2, pack(1000,2000,0,0,0,0,0,0), '0, 0, "R4 rmw two bytes"); endtask
  task automatic t_zero();   run_case(2'd1, 0, pack(104,105,0,0,0,0,0,0), '0, 0, "R6 zero count"); endtask
  task automatic t_erased8();
    logic [207:0] cd;
    cd = '0; cd[111:0] = '1;
    run_case(2'd1, 3, pack(104,200,300,0,0,0,0,0), cd, 0, "R7 erased strength8");
    cd[111:104] = 8'hFE;
    run_case(2'd1, 3, pack(104,200,300,0,0,0,0,0), cd, 0, "R7 one byte differs");
  endtask
  task automatic t_erased4();
    logic [207:0] cd;
    cd = '0; cd[55:0] = '1;
    run_case(2'd0, 2, pack(60,70,0,0,0,0,0,0), cd, 0, "R7 erased strength4");
  endtask
  task automatic t_clamp();  run_case(2'd0, 12, pack(52,100,200,300,400,500,600,4147), '0, 0, "R8 count clamp"); endtask
  task automatic t_busy();   run_case(2'd1, 3, pack(500,10,600,0,0,0,0,0), '0, 1, "R10 start while busy"); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map8();
    t_map4();
    t_map16();
    t_map16b();
    t_skip();
    t_order();
    t_rmw();
    t_zero();
    t_erased8();
    t_erased4();
    t_clamp();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule